// File: doc/BRIEF.md
# Quiescence Handshake Responder

This block sits on the device side of a two-wire quiescence handshake. A power controller pulls an active-low request line when it wants to stop the device's clock or power. The responder then stops issuing new internal transactions and waits for the outstanding ones to retire. It answers with one of two registered responses. An active-low accept means the device is idle and gating is safe. An active-high deny means the device must stay running. The controller then releases its request, and the responder withdraws whichever response it gave.

A deny comes from one of two causes. The first is a must-stay-on input that is high while the device drains. The second is a drain-timeout counter that expires before the outstanding count reaches zero. A legacy strap switches the deny path off entirely, so the responder can only accept, however long that takes. An activity output, formed combinationally, shows outstanding work or a pending issue attempt. Each of the three device-driven lines has a companion odd-parity check output.

Top module: `qch_responder`

## Requirements
- R1: While reset is held, accept_n_o is 1, deny_o is 0 and txn_grant_o is 0.
- R2: accept_n_o falls only after the request is seen low and the outstanding count is zero. It falls on the clock edge after the first draining cycle that sees a zero count, and never while deny_o is 1.
- R3: After an accept, accept_n_o returns to 1 on the clock edge after req_n_i is sampled 1.
- R4: With legacy_i at 0, a must-stay-on input at 1 during a draining cycle raises deny_o on the next edge. This takes priority over accepting.
- R5: With legacy_i at 0 and the drain still incomplete, deny_o rises exactly TIMEOUT+1 clock edges after req_n_i is first sampled low.
- R6: After a deny, deny_o returns to 0 on the clock edge after req_n_i is sampled 1. accept_n_o stays 1 throughout.
- R7: With legacy_i at 1, deny_o never rises. The responder waits for the outstanding count to reach zero and then accepts, whatever keep_on_i or the elapsed time.
- R8: txn_grant_o is 1 only when txn_start_i is 1 and the count is below its maximum (2^CNT_W-1), with no quiescence in progress. Quiescence means req_n_i is low in the running state, or the block is draining or stopped. During a deny, grants are allowed again.
- R9: active_o equals 1 whenever the outstanding count is non-zero or txn_start_i is 1.
- R10: accept_chk_o, deny_chk_o and active_chk_o each hold the inverse of their primary output, giving odd parity over the pair.
- R11: The pair accept_n_o=0 with deny_o=1 never occurs. Each edge of accept_n_o and deny_o obeys the ordering rules for request and the other response line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n_i | input | 1 | Quiescence request from controller, active low |
| legacy_i | input | 1 | Strap: 1 disables the deny path |
| keep_on_i | input | 1 | Must-stay-on condition |
| txn_start_i | input | 1 | Internal attempt to issue a transaction |
| txn_done_i | input | 1 | One outstanding transaction retires |
| txn_grant_o | output | 1 | Issue attempt is granted this cycle |
| accept_n_o | output | 1 | Quiescent response, active low, registered |
| deny_o | output | 1 | Refusal response, registered |
| active_o | output | 1 | Device has work pending |
| accept_chk_o | output | 1 | Odd-parity check for accept_n_o |
| deny_chk_o | output | 1 | Odd-parity check for deny_o |
| active_chk_o | output | 1 | Odd-parity check for active_o |

## Verification
Several properties are checked on every cycle by the assertions. These cover the edge-ordering rules for both response lines and the absence of the illegal accept-with-deny pair. They also cover accept only on an empty count, deny only with a cause and never under the legacy strap, and a count that never grows while quiescing. Some behaviours only the bench's scenarios can show. These include the exact timeout latency, the priority of the stay-on deny over a simultaneous drain, and saturation of the outstanding count. The scenarios also cover blocked issue attempts while stopped and the parity values. A cycle-level reference model covers all outputs on every clock.

// File: rtl/qch_pkg.sv
package qch_pkg;

  typedef enum logic [1:0] {
    QS_RUN   = 2'd0,
    QS_DRAIN = 2'd1,
    QS_STOP  = 2'd2,
    QS_DENY  = 2'd3
  } qstate_t;

  typedef enum logic [1:0] {
    QD_HOLD   = 2'd0,
    QD_TAKE   = 2'd1,
    QD_REFUSE = 2'd2
  } qdecide_t;

  // Outcome of one draining cycle; stay-on refusal outranks an idle accept.
  function automatic qdecide_t drain_decide(input logic legacy, input logic keep_on,
                                            input logic idle, input logic expired);
    if (!legacy && keep_on) return QD_REFUSE;
    if (idle)               return QD_TAKE;
    if (!legacy && expired) return QD_REFUSE;
    return QD_HOLD;
  endfunction

  // Odd parity companion bit.
  function automatic logic odd_chk(input logic v);
    return ~(^v);
  endfunction

endpackage

// File: rtl/qch_txn_tracker.sv
module qch_txn_tracker #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  input  logic block,
  output logic grant,
  output logic idle,
  output logic busy
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             full;
  logic             retire;

  assign full   = (cnt == CNT_MAX);
  assign grant  = start & ~block & ~full;
  assign retire = done & (cnt != '0);
  assign idle   = (cnt == '0);
  assign busy   = ~idle | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (grant & ~retire) cnt <= cnt + CNT_W'(1);
    else if (~grant & retire) cnt <= cnt - CNT_W'(1);
  end

  AST_CNT_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    block |=> (cnt <= $past(cnt))); // R8
  AST_BUSY_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !retire) |=> busy); // R9

endmodule

// File: rtl/qch_drain_timer.sv
module qch_drain_timer #(
  parameter int TIMEOUT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TMR_W = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);
  localparam logic [TMR_W-1:0] LAST = TMR_W'(TIMEOUT - 1);

  logic [TMR_W-1:0] tmr;

  assign expired = (tmr == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tmr <= '0;
    else if (!run)     tmr <= '0;
    else if (!expired) tmr <= tmr + TMR_W'(1);
  end

endmodule

// File: rtl/qch_hs_fsm.sv
module qch_hs_fsm
  import qch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic legacy,
  input  logic keep_on,
  input  logic idle,
  input  logic expired,
  output logic accept_n,
  output logic deny,
  output logic draining,
  output logic quiescing
);
  qstate_t  st;
  qdecide_t dec;

  assign dec       = drain_decide(legacy, keep_on, idle, expired);
  assign draining  = (st == QS_DRAIN);
  assign quiescing = draining | (st == QS_STOP) | ((st == QS_RUN) & ~req_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= QS_RUN;
      accept_n <= 1'b1;
      deny     <= 1'b0;
    end else begin
      case (st)
        QS_RUN:   if (!req_n) st <= QS_DRAIN;
        QS_DRAIN: begin
          if (dec == QD_TAKE) begin
            st       <= QS_STOP;
            accept_n <= 1'b0;
          end else if (dec == QD_REFUSE) begin
            st   <= QS_DENY;
            deny <= 1'b1;
          end
        end
        QS_STOP: if (req_n) begin
          st       <= QS_RUN;
          accept_n <= 1'b1;
        end
        default: if (req_n) begin
          st   <= QS_RUN;
          deny <= 1'b0;
        end
      endcase
    end
  end

  AST_NO_ILLEGAL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(!accept_n && deny)); // R11
  AST_ACC_FALL_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(accept_n) |-> $past(!req_n && !deny)); // R11
  AST_ACC_RISE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept_n) |-> $past(req_n && !deny)); // R3
  AST_DENY_RISE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deny) |-> $past(!req_n && accept_n)); // R11
  AST_DENY_FALL_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(deny) |-> $past(req_n && accept_n)); // R6
  AST_ACC_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(accept_n) |-> $past(idle)); // R2
  AST_DENY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deny) |-> $past(keep_on || expired)); // R4
  AST_LEGACY_NO_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deny) |-> !$past(legacy)); // R7

endmodule

// File: rtl/qch_parity.sv
module qch_parity
  import qch_pkg::*;
#(
  parameter int N = 3
) (
  input  logic [N-1:0] sig,
  output logic [N-1:0] chk
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign chk[i] = odd_chk(sig[i]);
  end
endmodule

// File: rtl/qch_responder.sv
module qch_responder #(
  parameter int CNT_W   = 4,
  parameter int TIMEOUT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_i,
  input  logic legacy_i,
  input  logic keep_on_i,
  input  logic txn_start_i,
  input  logic txn_done_i,
  output logic txn_grant_o,
  output logic accept_n_o,
  output logic deny_o,
  output logic active_o,
  output logic accept_chk_o,
  output logic deny_chk_o,
  output logic active_chk_o
);
  localparam int NCHK = 3;

  logic            ev_idle;
  logic            ev_expired;
  logic            ev_draining;
  logic            ev_quiescing;
  logic [NCHK-1:0] par_sig;
  logic [NCHK-1:0] par_chk;

  qch_txn_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (txn_start_i),
    .done  (txn_done_i),
    .block (ev_quiescing),
    .grant (txn_grant_o),
    .idle  (ev_idle),
    .busy  (active_o)
  );

  qch_drain_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ev_draining),
    .expired (ev_expired)
  );

  qch_hs_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_n     (req_n_i),
    .legacy    (legacy_i),
    .keep_on   (keep_on_i),
    .idle      (ev_idle),
    .expired   (ev_expired),
    .accept_n  (accept_n_o),
    .deny      (deny_o),
    .draining  (ev_draining),
    .quiescing (ev_quiescing)
  );

  assign par_sig = {active_o, deny_o, accept_n_o};

  qch_parity #(.N(NCHK)) u_par (
    .sig (par_sig),
    .chk (par_chk)
  );

  assign accept_chk_o = par_chk[0];
  assign deny_chk_o   = par_chk[1];
  assign active_chk_o = par_chk[2];

  AST_STOPPED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_n_o |-> !txn_grant_o); // R8

endmodule

// File: tb/qch_responder_bench.sv
module qch_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int TIMEOUT    = 8;
  localparam int CMAX       = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1, legacy = 1'b0, keep_on = 1'b0, start = 1'b0, done = 1'b0;
  logic grant, acc_n, deny, active, acc_chk, deny_chk, act_chk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference model state: 0 run, 1 drain, 2 stopped, 3 denied
  int m_st = 0, m_cnt = 0, m_tmr = 0;
  bit m_acc_n = 1, m_deny = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qch_responder #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_qch_responder (
    .clk(clk), .rst_n(rst_n), .req_n_i(req_n), .legacy_i(legacy),
    .keep_on_i(keep_on), .txn_start_i(start), .txn_done_i(done),
    .txn_grant_o(grant), .accept_n_o(acc_n), .deny_o(deny), .active_o(active),
    .accept_chk_o(acc_chk), .deny_chk_o(deny_chk), .active_chk_o(act_chk)
  );

  task automatic check(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_quiet();
    return (m_st == 1) || (m_st == 2) || (m_st == 0 && !req_n);
  endfunction

  function automatic bit m_grant();
    return start && !m_quiet() && (m_cnt < CMAX);
  endfunction

  task automatic compare();
    bit g, a;
    g = m_grant();
    a = (m_cnt != 0) || start;
    check("R2 R3 accept_n", acc_n, m_acc_n);
    check("R4 R6 deny", deny, m_deny);
    check("R8 grant", grant, g);
    check("R9 active", active, a);
    check("R10 accept_chk", acc_chk, ~acc_n);
    check("R10 deny_chk", deny_chk, ~deny);
    check("R10 active_chk", act_chk, ~active);
    check("R11 illegal pair", (!acc_n && deny), 1'b0);
  endtask

  task automatic model_update();
    bit g, r, idle, exp_hit;
    int ost;
    g = m_grant();
    r = done && (m_cnt > 0);
    idle = (m_cnt == 0);
    exp_hit = (m_tmr == TIMEOUT - 1);
    ost = m_st;
    if (ost == 1) begin
      if (!exp_hit) m_tmr++;
    end else m_tmr = 0;
    m_cnt = m_cnt + (g ? 1 : 0) - (r ? 1 : 0);
    case (ost)
      0: if (!req_n) m_st = 1;
      1: begin
        if (!legacy && keep_on) begin m_st = 3; m_deny = 1; end
        else if (idle) begin m_st = 2; m_acc_n = 0; end
        else if (!legacy && exp_hit) begin m_st = 3; m_deny = 1; end
      end
      2: if (req_n) begin m_st = 0; m_acc_n = 1; end
      default: if (req_n) begin m_st = 0; m_deny = 0; end
    endcase
  endtask

  // Inputs are set at a negedge before calling.
  task automatic step();
    #1;
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got hung expected completion");
    finish_run();
  end

  initial begin
    int n;
    int grants;
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R1 reset accept_n", acc_n, 1'b1);
    check("R1 reset deny", deny, 1'b0);
    check("R1 reset grant", grant, 1'b0);
    check("R1 reset active", active, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // plain accept path with empty drain
    start = 1; steps(3);
    start = 0; done = 1; steps(3);
    done = 0; req_n = 0; steps(3);
    check("R2 accept after idle drain", acc_n, 1'b0);
    start = 1; steps(3);               // blocked while stopped, active seen
    start = 0; req_n = 1; step();
    check("R3 accept released", acc_n, 1'b1);
    steps(2);

    // accept after outstanding work retires within timeout
    start = 1; steps(2);
    start = 0; req_n = 0; steps(3);
    check("R2 no accept while busy", acc_n, 1'b1);
    done = 1; steps(2);
    done = 0; steps(2);
    check("R2 accept after retire", acc_n, 1'b0);
    req_n = 1; steps(3);

    // stay-on deny, priority over an idle drain
    keep_on = 1; req_n = 0; steps(2);
    check("R4 stay-on deny", deny, 1'b1);
    check("R4 no accept with deny", acc_n, 1'b1);
    start = 1; step();                 // grants reopen while denied
    start = 0; req_n = 1; step();
    check("R6 deny released", deny, 1'b0);
    keep_on = 0; done = 1; steps(2);
    done = 0; steps(2);

    // timeout deny
    start = 1; step();
    start = 0; req_n = 0;
    n = 0;
    do begin step(); n++; end while (!deny && n < 50);
    check("R5 timeout latency", (n == TIMEOUT + 1), 1'b1);
    if (n != TIMEOUT + 1) $display("FAIL R5 latency: got %0d expected %0d", n, TIMEOUT + 1);
    req_n = 1; step();
    check("R6 deny dropped after timeout", deny, 1'b0);
    done = 1; step();
    done = 0; steps(2);

    // legacy strap: never deny
    legacy = 1; keep_on = 1;
    start = 1; step();
    start = 0; req_n = 0;
    for (int i = 0; i < 3 * TIMEOUT; i++) begin
      step();
      check("R7 legacy no deny", deny, 1'b0);
    end
    done = 1; step();
    done = 0; steps(2);
    check("R7 legacy accept", acc_n, 1'b0);
    req_n = 1; steps(2);
    legacy = 0; keep_on = 0;

    // saturation of the outstanding count
    grants = 0;
    start = 1;
    for (int i = 0; i < CMAX + 5; i++) begin
      #1;
      if (grant) grants++;
      step();
    end
    check("R8 saturation grant count", (grants == CMAX), 1'b1);
    start = 0; done = 1; steps(CMAX + 3);
    done = 0; step();
    check("R9 idle after drain", active, 1'b0);

    // request arriving in same cycle as an issue attempt
    start = 1; req_n = 0; step();
    start = 0; steps(2);
    req_n = 1; steps(3);

    finish_run();
  end
endmodule